// File: doc/BRIEF.md
# Half-Bridge Gate Enable and Switch Status Unit

This unit turns per-switch requests for a bank of half-bridges into gate-enable signals that are safe to hand to the gate drivers. Every bridge has a low-side and a high-side switch. A switch is enabled only when all of the following hold:

- it alone of its pair is requested;
- both the software run bit and the hardware run pin are high;
- no global fault disable is present;
- no per-switch fault disable is present.

A turn-on is held back until both switches of the bridge have rested for a dead time. The dead time is measured in clock cycles and defaults to 1 µs at a 200 MHz clock.

The unit also drives the enables for the open-load test currents. It builds one status bit per switch for the status word that is returned to the host. When open-load sensing is selected, a switch that is not commanded on receives its test current. Its status bit then carries the result of the open-load comparator. In every other case the status bit mirrors the switch's gate enable. A registered standby flag reports whether either run input is holding the bank off.

All inputs and outputs are plain level control and status signals. No stream interface is present, so there is no back-pressure.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With run active and no fault disable, a switch whose request is high while the other switch of its bridge is not requested has its gate enable high one clock after the request. This assumes the dead time of R3 has elapsed. Its gate enable falls one clock after the request falls.
- R2: When both requests of a bridge are high, both gate enables of that bridge are low one clock later. They stay low while both requests are held.
- R3: A gate enable of a bridge rises only after both enables of that bridge have been low for DEAD_CYCLES+1 consecutive clocks. A switch-over from one side to the other therefore leaves exactly DEAD_CYCLES+1 clocks with both low. The first turn-on after reset is not delayed.
- R4: When sw_run is 0 or hw_run is 0, every gate enable is low one clock later. Outputs resume only when both inputs are 1, subject to R3.
- R5: standby is a register that reads 1 in reset. One clock after the inputs change it equals NOT(sw_run AND hw_run).
- R6: A high glob_fault_off forces every gate enable low one clock later. A high bit of fault_off_lo or fault_off_hi forces only the matching switch low and leaves the others as requested.
- R7: The open-load test enable of a switch (ol_sink_lo for low side, ol_src_hi for high side) is 1 one clock after a cycle in which ol_det_n is 0 and that switch's request is 0. Otherwise it is 0 one clock later.
- R8: The status bit of a switch equals its open-load flag (1 = open load) while its test enable is 1, and equals its gate enable while its test enable is 0.
- R9: During reset all gate enables and test enables are 0 and standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lo_req | input | NUM_BRIDGES | Low-side switch requests, bit k = bridge k |
| hi_req | input | NUM_BRIDGES | High-side switch requests, bit k = bridge k |
| ol_det_n | input | 1 | Open-load sensing select, 0 = sensing on |
| ol_flag_lo | input | NUM_BRIDGES | Low-side open-load comparator flags, 1 = open |
| ol_flag_hi | input | NUM_BRIDGES | High-side open-load comparator flags, 1 = open |
| glob_fault_off | input | 1 | Supervisor disable of all switches |
| fault_off_lo | input | NUM_BRIDGES | Per-switch low-side disable |
| fault_off_hi | input | NUM_BRIDGES | Per-switch high-side disable |
| sw_run | input | 1 | Software run bit, 0 = inhibit |
| hw_run | input | 1 | Hardware run pin, 0 = inhibit |
| gate_lo | output | NUM_BRIDGES | Low-side gate enables |
| gate_hi | output | NUM_BRIDGES | High-side gate enables |
| ol_sink_lo | output | NUM_BRIDGES | Low-side open-load test current enables |
| ol_src_hi | output | NUM_BRIDGES | High-side open-load test current enables |
| stat_lo | output | NUM_BRIDGES | Low-side status bits |
| stat_hi | output | NUM_BRIDGES | High-side status bits |
| standby | output | 1 | 1 while either run input inhibits the outputs |

## Verification
The per-bridge quiet counter is the only hidden state. If its value is wrong, the fault shows at the gate pins. A new turn-on comes one or more clocks earlier or later than DEAD_CYCLES+1 clocks after the opposite side fell, or the first turn-on after reset is delayed. If a test-enable register is wrong, the status pins show it in the clock after the request or the sensing select changes: a flag appears where the gate state should be, or the reverse. Both faults become visible within one dead-time window of the stimulus.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } hb_pair_t;
endpackage

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYCLES = 200
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hb_pair_t req,
  input  logic     run,
  input  hb_pair_t fault_off,
  output hb_pair_t gate
);
  localparam int CW = $clog2(DEAD_CYCLES + 2);
  localparam logic [CW-1:0] QMAX = CW'(DEAD_CYCLES);

  hb_pair_t       want;
  logic [CW-1:0]  quiet;
  logic           quiet_done;

  always_comb begin
    want.hi    = req.hi & ~req.lo & run & ~fault_off.hi;
    want.lo    = req.lo & ~req.hi & run & ~fault_off.lo;
    quiet_done = (quiet == QMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate  <= '0;
      quiet <= QMAX;
    end else begin
      if (gate.hi | gate.lo)
        quiet <= '0;
      else if (!quiet_done)
        quiet <= quiet + CW'(1);
      gate.hi <= want.hi & (gate.hi | (quiet_done & ~gate.lo));
      gate.lo <= want.lo & (gate.lo | (quiet_done & ~gate.hi));
    end
  end
endmodule

// File: rtl/hb_sense.sv
module hb_sense #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ol_det_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] flag,
  input  logic [W-1:0] gate,
  output logic [W-1:0] test_en,
  output logic [W-1:0] stat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_en <= '0;
    else        test_en <= {W{~ol_det_n}} & ~req;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign stat[i] = test_en[i] ? flag[i] : gate[i];
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int NUM_BRIDGES = 6,
  parameter int DEAD_CYCLES = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_BRIDGES-1:0] lo_req,
  input  logic [NUM_BRIDGES-1:0] hi_req,
  input  logic                   ol_det_n,
  input  logic [NUM_BRIDGES-1:0] ol_flag_lo,
  input  logic [NUM_BRIDGES-1:0] ol_flag_hi,
  input  logic                   glob_fault_off,
  input  logic [NUM_BRIDGES-1:0] fault_off_lo,
  input  logic [NUM_BRIDGES-1:0] fault_off_hi,
  input  logic                   sw_run,
  input  logic                   hw_run,
  output logic [NUM_BRIDGES-1:0] gate_lo,
  output logic [NUM_BRIDGES-1:0] gate_hi,
  output logic [NUM_BRIDGES-1:0] ol_sink_lo,
  output logic [NUM_BRIDGES-1:0] ol_src_hi,
  output logic [NUM_BRIDGES-1:0] stat_lo,
  output logic [NUM_BRIDGES-1:0] stat_hi,
  output logic                   standby
);
  logic run_ok;
  logic allow;

  assign run_ok = sw_run & hw_run;
  assign allow  = run_ok & ~glob_fault_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) standby <= 1'b1;
    else        standby <= ~run_ok;
  end

  for (genvar k = 0; k < NUM_BRIDGES; k++) begin : g_leg
    hb_pair_t req_k, off_k, gate_k;
    assign req_k = '{hi: hi_req[k], lo: lo_req[k]};
    assign off_k = '{hi: fault_off_hi[k], lo: fault_off_lo[k]};

    hb_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_k),
      .run       (allow),
      .fault_off (off_k),
      .gate      (gate_k)
    );

    assign gate_hi[k] = gate_k.hi;
    assign gate_lo[k] = gate_k.lo;
  end

  hb_sense #(.W(NUM_BRIDGES)) u_sense_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .ol_det_n (ol_det_n),
    .req      (lo_req),
    .flag     (ol_flag_lo),
    .gate     (gate_lo),
    .test_en  (ol_sink_lo),
    .stat     (stat_lo)
  );

  hb_sense #(.W(NUM_BRIDGES)) u_sense_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .ol_det_n (ol_det_n),
    .req      (hi_req),
    .flag     (ol_flag_hi),
    .gate     (gate_hi),
    .test_en  (ol_src_hi),
    .stat     (stat_hi)
  );
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int NUM_BRIDGES = 6,
  parameter int DEAD_CYCLES = 200
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_BRIDGES-1:0] lo_req,
  input logic [NUM_BRIDGES-1:0] hi_req,
  input logic                   ol_det_n,
  input logic [NUM_BRIDGES-1:0] ol_flag_lo,
  input logic [NUM_BRIDGES-1:0] ol_flag_hi,
  input logic                   glob_fault_off,
  input logic [NUM_BRIDGES-1:0] fault_off_lo,
  input logic [NUM_BRIDGES-1:0] fault_off_hi,
  input logic                   sw_run,
  input logic                   hw_run,
  input logic [NUM_BRIDGES-1:0] gate_lo,
  input logic [NUM_BRIDGES-1:0] gate_hi,
  input logic [NUM_BRIDGES-1:0] ol_sink_lo,
  input logic [NUM_BRIDGES-1:0] ol_src_hi,
  input logic [NUM_BRIDGES-1:0] stat_lo,
  input logic [NUM_BRIDGES-1:0] stat_hi,
  input logic                   standby
);
  localparam int CW = $clog2(DEAD_CYCLES + 2);

  // R4
  inhibit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_run || !hw_run) |=> (gate_lo == '0 && gate_hi == '0));

  // R5
  standby_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_run && hw_run) |=> !standby);

  // R6
  glob_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob_fault_off |=> (gate_lo == '0 && gate_hi == '0));

  for (genvar k = 0; k < NUM_BRIDGES; k++) begin : g_br
    logic [CW-1:0] quiet;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        quiet <= '0;
        seen  <= 1'b0;
      end else begin
        seen <= seen | gate_lo[k] | gate_hi[k];
        if (gate_lo[k] | gate_hi[k])  quiet <= '0;
        else if (quiet != CW'(DEAD_CYCLES)) quiet <= quiet + CW'(1);
      end
    end

    // R2
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_lo[k] && gate_hi[k]));

    // R2
    both_req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_req[k] && hi_req[k]) |=> (!gate_lo[k] && !gate_hi[k]));

    // R3
    dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_hi[k]) && seen) |-> ($past(quiet) == CW'(DEAD_CYCLES)));

    // R3
    dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(gate_lo[k]) && seen) |-> ($past(quiet) == CW'(DEAD_CYCLES)));

    // R7
    test_off_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ol_src_hi[k] |-> !gate_hi[k]) and (ol_sink_lo[k] |-> !gate_lo[k]));

    // R8
    stat_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ol_src_hi[k] |-> (stat_hi[k] == gate_hi[k])) and
      (!ol_sink_lo[k] |-> (stat_lo[k] == gate_lo[k])));
  end
endmodule

bind hb_gate_ctrl hb_gate_chk #(
  .NUM_BRIDGES(NUM_BRIDGES),
  .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (.*);

// File: tb/sim_hb_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hb_gate_ctrl;
  localparam int N = 6;
  localparam int D = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lo_req = '0, hi_req = '0;
  logic ol_det_n = 1'b1;
  logic [N-1:0] ol_flag_lo = '0, ol_flag_hi = '0;
  logic glob_fault_off = 1'b0;
  logic [N-1:0] fault_off_lo = '0, fault_off_hi = '0;
  logic sw_run = 1'b1, hw_run = 1'b1;
  logic [N-1:0] gate_lo, gate_hi, ol_sink_lo, ol_src_hi, stat_lo, stat_hi;
  logic standby;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_gate_ctrl #(.NUM_BRIDGES(N), .DEAD_CYCLES(D)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    lo_req = '0; hi_req = '0; ol_det_n = 1'b1; glob_fault_off = 1'b0;
    fault_off_lo = '0; fault_off_hi = '0; sw_run = 1'b1; hw_run = 1'b1;
    step(D + 4);
  endtask

  task automatic t_reset();
    step(2);
    check("R9 gate_lo in reset", 32'(gate_lo), 0);
    check("R9 gate_hi in reset", 32'(gate_hi), 0);
    check("R9 test enables in reset", 32'({ol_sink_lo, ol_src_hi}), 0);
    check("R9 standby in reset", 32'(standby), 1);
    rst_n = 1'b1;
    step(1);
    check("R5 standby low after reset", 32'(standby), 0);
  endtask

  task automatic t_follow();
    hi_req = 6'b000101; lo_req = 6'b010000;
    step(1);
    check("R1 R3 first turn-on hi immediate", 32'(gate_hi), 32'h05);
    check("R1 first turn-on lo immediate", 32'(gate_lo), 32'h10);
    hi_req = 6'b000001;
    step(1);
    check("R1 gate falls with request", 32'(gate_hi), 32'h01);
    idle();
  endtask

  task automatic t_both();
    hi_req = 6'b000011; lo_req = 6'b000010;
    step(1);
    check("R2 both requested -> both off hi", 32'(gate_hi), 32'h01);
    check("R2 both requested -> both off lo", 32'(gate_lo), 0);
    step(D + 5);
    check("R2 still off while both held", 32'({gate_hi[1], gate_lo[1]}), 0);
    idle();
  endtask

  task automatic t_dead();
    hi_req = 6'b000001;
    step(1);
    check("R3 hi on before switch-over", 32'(gate_hi[0]), 1);
    hi_req = '0; lo_req = 6'b000001;
    step(D + 1);
    check("R3 both low at end of dead window", 32'({gate_hi[0], gate_lo[0]}), 0);
    step(1);
    check("R3 lo on after dead window", 32'(gate_lo[0]), 1);
    idle();
  endtask

  task automatic t_inhibit();
    hi_req = 6'b111000; lo_req = 6'b000111;
    step(1);
    check("R1 all bridges on", 32'({gate_hi, gate_lo}), 32'hE07);
    sw_run = 1'b0;
    step(1);
    check("R4 sw inhibit gates off", 32'({gate_hi, gate_lo}), 0);
    check("R5 standby on sw inhibit", 32'(standby), 1);
    sw_run = 1'b1; hw_run = 1'b0;
    step(D + 5);
    check("R4 hw inhibit keeps gates off", 32'({gate_hi, gate_lo}), 0);
    check("R5 standby on hw inhibit", 32'(standby), 1);
    hw_run = 1'b1;
    step(1);
    check("R4 outputs resume", 32'({gate_hi, gate_lo}), 32'hE07);
    check("R5 standby cleared", 32'(standby), 0);
    idle();
  endtask

  task automatic t_fault();
    hi_req = 6'b000011; lo_req = 6'b001100;
    fault_off_hi = 6'b000001; fault_off_lo = 6'b001000;
    step(1);
    check("R6 per-switch hi fault", 32'(gate_hi), 32'h02);
    check("R6 per-switch lo fault", 32'(gate_lo), 32'h04);
    glob_fault_off = 1'b1;
    step(1);
    check("R6 global fault", 32'({gate_hi, gate_lo}), 0);
    idle();
  endtask

  task automatic t_openload();
    hi_req = 6'b000001; ol_det_n = 1'b0;
    ol_flag_hi = 6'b101010; ol_flag_lo = 6'b000111;
    step(1);
    check("R7 hi test enables", 32'(ol_src_hi), 32'h3E);
    check("R7 lo test enables", 32'(ol_sink_lo), 32'h3F);
    check("R8 hi status mixes gate and flag", 32'(stat_hi), 32'h2B);
    check("R8 lo status reports flags", 32'(stat_lo), 32'h07);
    ol_det_n = 1'b1;
    step(1);
    check("R7 test enables off", 32'({ol_src_hi, ol_sink_lo}), 0);
    check("R8 status mirrors gates hi", 32'(stat_hi), 32'h01);
    check("R8 status mirrors gates lo", 32'(stat_lo), 0);
    idle();
  endtask

  initial begin
    t_reset();
    idle();
    t_follow();
    t_both();
    t_dead();
    t_inhibit();
    t_fault();
    t_openload();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule